// File: doc/BRIEF.md
# Constant Load Verification CAM

This block is a small fully associative table that lets a load predicted to return a constant value skip the data cache. When such a load is classed as constant, its data address and its value-table index (the low-order bits of the load's instruction address) are written into the table as one key. Later, when the same load executes again, the pipeline presents the same two fields as a search. A hit means no store has written that address since the entry was made, so the predicted value is still coherent with memory. The load then needs no memory check, and the pipeline may cancel any retry it has queued after a bank conflict or any miss request it has raised for that load.

Every store snoops the table with its data address and removes every entry holding that address, whatever index the entry carries. A search that misses raises a demotion flag. The load is then treated as merely predictable, and its value is compared against the data the cache returns. When the table is full, new keys replace entries in round-robin order. Insertions and invalidations take effect at the next clock edge. Search results are combinational on the current contents and on any store in the same cycle.

Top module: `const_verify_cam`

## Requirements
- R1: After reset the table holds no entries, so every search misses and raises `demote_o`.
- R2: The key is the data address concatenated with the index. A search hits only when a valid entry matches both fields. While `srch_valid_i` is high, exactly one of `hit_o` and `demote_o` is high. While it is low, both are low.
- R3: A key inserted in one cycle is found by a search in any later cycle, as long as no store to its address or eviction has removed it.
- R4: A store removes every entry whose address equals the store address, for all index values. Entries holding other addresses are unaffected.
- R5: A store and a search on the same address in the same cycle give a miss with demotion, even if the key was present.
- R6: Inserting a key that is already present creates no second entry and does not change the replacement order.
- R7: An insertion takes the lowest-numbered invalid entry when one exists. No valid entry is displaced in that case.
- R8: An insertion into a full table overwrites the entry named by a round-robin pointer. The pointer starts at entry 0 after reset, advances by one on each such overwrite, and wraps after the last entry.
- R9: An insertion whose address equals a same-cycle store address is dropped. An insertion beside a store to a different address completes.
- R10: A search in the same cycle as the insertion of its key sees the table as it was before the insertion, and misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ins_valid_i | input | 1 | Insert a key for a load classed as constant |
| ins_addr_i | input | ADDR_W | Data address of the inserted load |
| ins_idx_i | input | IDX_W | Value-table index of the inserted load |
| srch_valid_i | input | 1 | Search for an executing constant load |
| srch_addr_i | input | ADDR_W | Data address of the searching load |
| srch_idx_i | input | IDX_W | Value-table index of the searching load |
| st_valid_i | input | 1 | Store snoop valid |
| st_addr_i | input | ADDR_W | Store data address |
| hit_o | output | 1 | Search hit; prediction is coherent and no memory check is needed |
| demote_o | output | 1 | Search miss; load is demoted and must be checked against memory |

## Verification
The main interaction is a store snoop in the same cycle as a search or an insertion. A store can remove the very key being searched, or race an insertion of its own address. The directed part of the bench places a store and a search on one present address in the same cycle and expects a demotion. It also places a store and an insert on one address and expects a later search to miss. The random part draws addresses from a small pool so that stores, inserts and searches often collide. A reference table kept per requirement predicts each cycle's outcome.

// File: rtl/cvu_pkg.sv
`timescale 1ns/1ps
package cvu_pkg;
  localparam int unsigned CVU_ADDR_W  = 32;
  localparam int unsigned CVU_IDX_W   = 10;
  localparam int unsigned CVU_ENTRIES = 32;

  typedef enum logic [1:0] {
    INS_IDLE,
    INS_REFRESH,
    INS_FILL,
    INS_EVICT
  } ins_kind_e;
endpackage

// File: rtl/cvu_match.sv
`timescale 1ns/1ps
module cvu_match #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IDX_W   = 10
) (
  input  logic [ENTRIES-1:0]             valid_i,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] addr_i,
  input  logic [ENTRIES-1:0][IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0]              srch_addr_i,
  input  logic [IDX_W-1:0]               srch_idx_i,
  input  logic [ADDR_W-1:0]              ins_addr_i,
  input  logic [IDX_W-1:0]               ins_idx_i,
  input  logic [ADDR_W-1:0]              st_addr_i,
  output logic [ENTRIES-1:0]             srch_hit_o,
  output logic [ENTRIES-1:0]             ins_hit_o,
  output logic [ENTRIES-1:0]             st_hit_o
);
  localparam int unsigned KEY_W = ADDR_W + IDX_W;

  logic [KEY_W-1:0] srch_key, ins_key;
  assign srch_key = {srch_addr_i, srch_idx_i};
  assign ins_key  = {ins_addr_i, ins_idx_i};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [KEY_W-1:0] ent_key;
    assign ent_key       = {addr_i[g], idx_i[g]};
    assign srch_hit_o[g] = valid_i[g] && (ent_key == srch_key);
    assign ins_hit_o[g]  = valid_i[g] && (ent_key == ins_key);
    // store snoop compares the address field only
    assign st_hit_o[g]   = valid_i[g] && (addr_i[g] == st_addr_i);
  end
endmodule

// File: rtl/cvu_alloc.sv
`timescale 1ns/1ps
module cvu_alloc #(
  parameter int unsigned ENTRIES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               req_i,
  output logic [ENTRIES-1:0] slot_o,
  output logic               evict_o
);
  localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0]   rr_q;
  logic [ENTRIES-1:0] free_oh, victim_oh;
  logic               full, found;

  assign full = &valid_i;

  always_comb begin
    free_oh = '0;
    found   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_i[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign victim_oh = {{(ENTRIES-1){1'b0}}, 1'b1} << rr_q;
  assign slot_o    = full ? victim_oh : free_oh;
  assign evict_o   = req_i && full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rr_q <= '0;
    else if (evict_o) rr_q <= (rr_q == PTR_LAST) ? '0 : rr_q + 1'b1;
  end

  a_r8_slot_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> $onehot(slot_o));

  a_r7_free_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !full) |-> ((slot_o & valid_i) == '0));

  a_r8_rr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_o |=> (rr_q == (($past(rr_q) == PTR_LAST) ? '0 : $past(rr_q) + 1'b1)));

  a_r8_rr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evict_o |=> $stable(rr_q));
endmodule

// File: rtl/const_verify_cam.sv
`timescale 1ns/1ps
module const_verify_cam
  import cvu_pkg::*;
#(
  parameter int unsigned ADDR_W  = CVU_ADDR_W,
  parameter int unsigned IDX_W   = CVU_IDX_W,
  parameter int unsigned ENTRIES = CVU_ENTRIES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_valid_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic [IDX_W-1:0]  ins_idx_i,
  input  logic              srch_valid_i,
  input  logic [ADDR_W-1:0] srch_addr_i,
  input  logic [IDX_W-1:0]  srch_idx_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  output logic              hit_o,
  output logic              demote_o
);
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] addr_q;
  logic [ENTRIES-1:0][IDX_W-1:0]  idx_q;

  logic [ENTRIES-1:0] srch_hit_vec, ins_hit_vec, st_hit_vec;
  logic [ENTRIES-1:0] kill_vec, live_vec, slot_vec, write_vec;
  logic               ins_block, ins_dup, alloc_req, evict;
  ins_kind_e          ins_kind;

  cvu_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
    .valid_i     (valid_q),
    .addr_i      (addr_q),
    .idx_i       (idx_q),
    .srch_addr_i (srch_addr_i),
    .srch_idx_i  (srch_idx_i),
    .ins_addr_i  (ins_addr_i),
    .ins_idx_i   (ins_idx_i),
    .st_addr_i   (st_addr_i),
    .srch_hit_o  (srch_hit_vec),
    .ins_hit_o   (ins_hit_vec),
    .st_hit_o    (st_hit_vec)
  );

  // same-cycle store beats a search on the entries it hits
  assign kill_vec = {ENTRIES{st_valid_i}} & st_hit_vec;
  assign live_vec = srch_hit_vec & ~kill_vec;
  assign hit_o    = srch_valid_i && (|live_vec);
  assign demote_o = srch_valid_i && !(|live_vec);

  assign ins_block = ins_valid_i && st_valid_i && (st_addr_i == ins_addr_i);
  assign ins_dup   = |ins_hit_vec;
  assign alloc_req = ins_valid_i && !ins_block && !ins_dup;

  cvu_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_q),
    .req_i   (alloc_req),
    .slot_o  (slot_vec),
    .evict_o (evict)
  );

  assign write_vec = {ENTRIES{alloc_req}} & slot_vec;

  always_comb begin
    if (!ins_valid_i || ins_block) ins_kind = INS_IDLE;
    else if (ins_dup)              ins_kind = INS_REFRESH;
    else if (evict)                ins_kind = INS_EVICT;
    else                           ins_kind = INS_FILL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (write_vec[e]) begin
          valid_q[e] <= 1'b1;
          addr_q[e]  <= ins_addr_i;
          idx_q[e]   <= ins_idx_i;
        end else if (kill_vec[e]) begin
          valid_q[e] <= 1'b0;
        end
      end
    end
  end

  a_r5_store_beats_search: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && srch_valid_i && (st_addr_i == srch_addr_i)) |-> (demote_o && !hit_o));

  a_r3_insert_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && !ins_block) |=>
      (!(srch_valid_i && (srch_addr_i == $past(ins_addr_i)) && (srch_idx_i == $past(ins_idx_i))
         && !(st_valid_i && (st_addr_i == srch_addr_i))) || hit_o));

  a_r4_store_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i |=> !(hit_o && (srch_addr_i == $past(st_addr_i))));

  a_r9_insert_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_block |=> !(hit_o && (srch_addr_i == $past(ins_addr_i))));

  a_r6_no_duplicate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i |-> ($countones(ins_hit_vec) <= 1));

  a_r7_fill_not_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_kind == INS_FILL) |-> !(&valid_q));
endmodule

// File: tb/const_verify_cam_tb.sv
`timescale 1ns/1ps
module const_verify_cam_tb;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned ENTRIES = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ins_valid, srch_valid, st_valid;
  logic [ADDR_W-1:0] ins_addr, srch_addr, st_addr;
  logic [IDX_W-1:0]  ins_idx, srch_idx;
  logic hit, demote;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  const_verify_cam #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ins_valid_i(ins_valid), .ins_addr_i(ins_addr), .ins_idx_i(ins_idx),
    .srch_valid_i(srch_valid), .srch_addr_i(srch_addr), .srch_idx_i(srch_idx),
    .st_valid_i(st_valid), .st_addr_i(st_addr),
    .hit_o(hit), .demote_o(demote)
  );

  // reference table built from the requirements
  bit                m_v [ENTRIES];
  logic [ADDR_W-1:0] m_a [ENTRIES];
  logic [IDX_W-1:0]  m_i [ENTRIES];
  int                m_rr;

  function automatic logic [ADDR_W-1:0] ka(int k);
    return ADDR_W'(32'h4000_0000 + k * 16);
  endfunction

  function automatic bit model_hit(logic [ADDR_W-1:0] a, logic [IDX_W-1:0] i,
                                   bit tv, logic [ADDR_W-1:0] ta);
    bit h = 1'b0;
    for (int e = 0; e < ENTRIES; e++)
      if (m_v[e] && m_a[e] == a && m_i[e] == i) h = 1'b1;
    if (tv && ta == a) h = 1'b0;  // R5
    return h;
  endfunction

  task automatic model_step(bit iv, logic [ADDR_W-1:0] ia, logic [IDX_W-1:0] ii,
                            bit tv, logic [ADDR_W-1:0] ta);
    bit dup = 1'b0;
    int slot = -1;
    for (int e = 0; e < ENTRIES; e++) begin
      if (m_v[e] && m_a[e] == ia && m_i[e] == ii) dup = 1'b1;
      if (!m_v[e] && slot < 0) slot = e;
    end
    for (int e = 0; e < ENTRIES; e++)
      if (tv && m_v[e] && m_a[e] == ta) m_v[e] = 1'b0;
    if (iv && !(tv && ta == ia) && !dup) begin
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % ENTRIES;
      end
      m_v[slot] = 1'b1;
      m_a[slot] = ia;
      m_i[slot] = ii;
    end
  endtask

  task automatic step(bit iv, logic [ADDR_W-1:0] ia, logic [IDX_W-1:0] ii,
                      bit sv, logic [ADDR_W-1:0] sa, logic [IDX_W-1:0] si,
                      bit tv, logic [ADDR_W-1:0] ta, string tag);
    bit eh, ed;
    @(negedge clk);
    ins_valid = iv; ins_addr = ia; ins_idx = ii;
    srch_valid = sv; srch_addr = sa; srch_idx = si;
    st_valid = tv; st_addr = ta;
    #1;
    eh = sv && model_hit(sa, si, tv, ta);
    ed = sv && !eh;
    n_chk++;
    if (hit !== eh || demote !== ed) begin
      n_fail++;
      $display("FAIL %s: hit=%b demote=%b expected hit=%b demote=%b (addr=%h idx=%0d)",
               tag, hit, demote, eh, ed, sa, si);
    end
    @(posedge clk);
    model_step(iv, ia, ii, tv, ta);
  endtask

  task automatic ins(int k, int i, string tag);
    step(1'b1, ka(k), IDX_W'(i), 1'b0, '0, '0, 1'b0, '0, tag);
  endtask
  task automatic srch(int k, int i, string tag);
    step(1'b0, '0, '0, 1'b1, ka(k), IDX_W'(i), 1'b0, '0, tag);
  endtask
  task automatic store(int k, string tag);
    step(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, ka(k), tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    ins_valid = 1'b0; srch_valid = 1'b0; st_valid = 1'b0;
    ins_addr = '0; ins_idx = '0; srch_addr = '0; srch_idx = '0; st_addr = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      m_v[e] = 1'b0; m_a[e] = '0; m_i[e] = '0;
    end
    m_rr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();

    // R1: empty after reset
    srch(0, 0, "R1");
    srch(7, 3, "R1");
    // R2: no search, both outputs low
    step(1'b0, '0, '0, 1'b0, '0, '0, 1'b0, '0, "R2");

    // R10: search concurrent with the insert of its key misses
    step(1'b1, ka(1), 10'd0, 1'b1, ka(1), 10'd0, 1'b0, '0, "R10");
    // R3: visible next cycle
    srch(1, 0, "R3");
    // R2: both key fields must match
    srch(1, 1, "R2");
    srch(2, 0, "R2");

    // R4: store removes every index under its address only
    ins(1, 1, "R4");
    ins(2, 0, "R4");
    store(1, "R4");
    srch(1, 0, "R4");
    srch(1, 1, "R4");
    srch(2, 0, "R4");

    // R5: store and search on a present key in one cycle
    ins(3, 2, "R5");
    step(1'b0, '0, '0, 1'b1, ka(3), 10'd2, 1'b1, ka(3), "R5");
    srch(3, 2, "R5");

    // R9: insert dropped by same-address store, kept beside another store
    step(1'b1, ka(4), 10'd0, 1'b0, '0, '0, 1'b1, ka(4), "R9");
    srch(4, 0, "R9");
    step(1'b1, ka(5), 10'd0, 1'b0, '0, '0, 1'b1, ka(2), "R9");
    srch(5, 0, "R9");
    srch(2, 0, "R9");

    // R6: duplicate insert must not consume an entry
    do_reset();
    ins(0, 0, "R6");
    ins(1, 0, "R6");
    ins(0, 0, "R6");
    for (int k = 2; k < ENTRIES; k++) ins(k, 0, "R6");
    for (int k = 0; k < ENTRIES; k++) srch(k, 0, "R6");
    ins(40, 0, "R6");
    srch(0, 0, "R6");
    srch(1, 0, "R6");

    // R7 / R8: fill order and round-robin replacement
    do_reset();
    for (int k = 0; k < ENTRIES; k++) ins(k, 0, "R7");
    for (int k = 0; k < ENTRIES; k++) srch(k, 0, "R7");
    ins(40, 0, "R8");
    srch(0, 0, "R8");
    srch(1, 0, "R8");
    ins(41, 0, "R8");
    srch(1, 0, "R8");
    srch(2, 0, "R8");
    store(5, "R7");
    ins(42, 0, "R7");
    for (int k = 2; k < ENTRIES; k++) srch(k, 0, "R7");
    srch(42, 0, "R7");
    ins(43, 0, "R8");
    srch(2, 0, "R8");
    srch(3, 0, "R8");

    // random traffic over a small key pool, R2 with all interactions
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      bit iv, sv, tv;
      int ik, sk, tk, ii, si;
      iv = ($urandom_range(99) < 45);
      sv = ($urandom_range(99) < 70);
      tv = ($urandom_range(99) < 12);
      ik = $urandom_range(23); sk = $urandom_range(23); tk = $urandom_range(23);
      ii = $urandom_range(3);  si = $urandom_range(3);
      if ($urandom_range(9) < 2) sk = ik;
      if ($urandom_range(9) < 2) tk = sk;
      step(iv, ka(ik), IDX_W'(ii), sv, ka(sk), IDX_W'(si), tv, ka(tk), "R2");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule